// File: doc/BRIEF.md
# Debug Exception Cause and Entry Unit

This block sits beside the issue stage of a processor core and decides, for every instruction presented to it, whether that instruction is replaced by a debug exception. Four kinds of trigger can apply. The first is an instruction-address breakpoint with one address register and an enable bit. The second is an instruction counter that gives single-step traps. The third is a data-breakpoint hit that a neighbouring unit reports together with its channel number. The fourth is the 3-byte and 2-byte break instructions. All four are suppressed while the core already runs at or above the fixed debug interrupt level, which is 6.

When an exception is taken, the block pulses a strobe one cycle after the instruction was presented. In that same cycle it gives the cause value with exactly one trigger bit set, the address of the trapped instruction (which does not execute), and the new low five status bits. The core's vector fetch and return logic consume these outputs. Software programs the breakpoint address, the enable, the counter and the counter's level threshold through a simple write port.

Top module: `dbg_entry_unit`

## Requirements
- R1: After a synchronous active-low reset, `take_exc`, `cause`, `save_pc` and `ps_low` are zero, the breakpoint is disabled, and the counter and its threshold are zero, so that an instruction at address 0 takes no exception.
- R2: No exception is taken for an instruction issued while `cur_level` is 6 or higher, whatever triggers are present.
- R3: Cause bits are one-hot within bits 4..0: counter trap = bit 0 (0x1), address breakpoint = bit 1 (0x2), data breakpoint = bit 2 (0x4), 3-byte break = bit 3 (0x8), 2-byte break = bit 4 (0x10). For a data breakpoint, bits 8 and up carry the channel number.
- R4: When several triggers hold at once, only the highest-priority one is reported: counter, then address breakpoint, then data breakpoint, then 3-byte break, then 2-byte break.
- R5: On a taken exception, the outputs appear in the cycle after issue: `take_exc` is 1, `ps_low` is 0x16 (exception-mode bit 4 set, level field = 6), and `save_pc` is the PC of the trapped instruction.
- R6: The address breakpoint fires only when bit 0 of the enable register is 1 and `issue_pc` equals the programmed address. Writing a value with bit 0 clear stops further hits.
- R7: The counter increments once for each executed (not trapped) instruction issued while `cur_level` is below the threshold. A counter trap fires when the counter is all ones and the issuing level is below the threshold. When the counter is loaded with -2, one instruction completes and the next one traps with cause 0x1. A trapped instruction does not advance the counter.
- R8: A threshold of 0 disables counting and counter traps.
- R9: Register writes use `reg_sel` 0 = breakpoint address, 1 = enable, 2 = counter, 3 = threshold. A write affects only instructions issued in later cycles. An instruction issued in the same cycle as the write sees the old value.
- R10: In a cycle with no taken exception, `cause`, `save_pc` and `ps_low` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is about to execute this cycle |
| issue_pc | input | AW | Address of that instruction |
| is_brk3 | input | 1 | The instruction is a 3-byte break |
| is_brk2 | input | 1 | The instruction is a 2-byte break |
| dhit | input | 1 | Data breakpoint hit for this instruction |
| dhit_chan | input | DCH_W | Channel that hit |
| cur_level | input | LVL_W | Current interrupt level |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | DW | Write data |
| take_exc | output | 1 | Debug exception taken for last cycle's instruction |
| cause | output | 8+DCH_W | Debug cause value |
| save_pc | output | AW | PC saved on entry |
| ps_low | output | LVL_W+1 | New low status bits (mode bit, level) |

## Verification
The checker assumes that `issue_pc` and `cur_level` stay fixed for the one cycle they are sampled, and that the two break flags are never set together. It also assumes `cur_level` can reach any value of its width, because it checks the level gate against the raw input. The bench drives each instruction for exactly one cycle with at most one break flag set. It sweeps every level from 0 to 15 against every mix of counter, breakpoint, data-hit and break-type triggers, and it rewrites all four registers before each trial, so each trial starts from a known state.

// File: rtl/dbg_entry_pkg.sv
// Package: shared constants and types for the debug entry unit.
// Assumes: the debug level is fixed at build time.
package dbg_entry_pkg;
    localparam int DEBUG_LEVEL = 6;
    localparam int NUM_SRC     = 5;
    localparam int CHAN_LSB    = 8;

    // Trigger index; the index is also the cause bit position and the priority (0 highest).
    localparam int SRC_ICOUNT = 0;
    localparam int SRC_IBRK   = 1;
    localparam int SRC_DBRK   = 2;
    localparam int SRC_BRK3   = 3;
    localparam int SRC_BRK2   = 4;

    typedef enum logic [1:0] {
        SEL_IB_ADDR = 2'd0,
        SEL_IB_EN   = 2'd1,
        SEL_ICNT    = 2'd2,
        SEL_ICLVL   = 2'd3
    } dbg_sel_e;
endpackage

// File: rtl/dbg_ibreak_unit.sv
// Module: single instruction-address breakpoint comparator with enable.
// Assumes: writes take effect at the clock edge; the compare uses registered state only.
module dbg_ibreak_unit #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] wdata_addr,
    input  logic          wdata_en,
    input  logic [AW-1:0] pc,
    output logic          hit
);
    logic [AW-1:0] bp_addr;
    logic          bp_on;

    // Holds the programmed address and the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_addr <= '0;
            bp_on   <= 1'b0;
        end else begin
            if (wr_addr) bp_addr <= wdata_addr;
            if (wr_en)   bp_on   <= wdata_en;
        end
    end

    // Flags a match on the current PC when enabled.
    always_comb begin
        hit = bp_on && (pc == bp_addr);
    end
endmodule

// File: rtl/dbg_icount_unit.sv
// Module: instruction counter with level threshold for single-step traps.
// Assumes: retire is high only for instructions that actually execute.
module dbg_icount_unit #(
    parameter int CNT_W = 32,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic             wr_lvl,
    input  logic [CNT_W-1:0] wdata_cnt,
    input  logic [LVL_W-1:0] wdata_lvl,
    input  logic [LVL_W-1:0] cur_level,
    input  logic             retire,
    output logic             fire
);
    logic [CNT_W-1:0] count;
    logic [LVL_W-1:0] thresh;
    logic             eligible;

    // Decides whether the current level lets counting happen.
    always_comb begin
        eligible = cur_level < thresh;
        fire     = eligible && (&count);
    end

    // Counter: a write wins over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                 count <= '0;
        else if (wr_cnt)            count <= wdata_cnt;
        else if (retire && eligible) count <= count + CNT_W'(1);
    end

    // Threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)      thresh <= '0;
        else if (wr_lvl) thresh <= wdata_lvl;
    end
endmodule

// File: rtl/dbg_cause_arb.sv
// Module: fixed-priority picker that builds a one-hot cause value.
// Assumes: request index 0 has the highest priority; the data-breakpoint index carries a channel.
module dbg_cause_arb #(
    parameter int DCH_W   = 2,
    parameter int CAUSE_W = 8 + DCH_W
) (
    input  logic [dbg_entry_pkg::NUM_SRC-1:0] req,
    input  logic [DCH_W-1:0]                  chan,
    output logic [CAUSE_W-1:0]                cause,
    output logic                              any
);
    import dbg_entry_pkg::*;

    logic [NUM_SRC-1:0] above;

    // Marks, for each index, whether a higher-priority request is present.
    always_comb begin
        above[0] = 1'b0;
        for (int i = 1; i < NUM_SRC; i++) begin
            above[i] = above[i-1] | req[i-1];
        end
    end

    // Builds the cause value from the winning request.
    always_comb begin
        cause = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            cause[i] = req[i] & ~above[i];
        end
        if (cause[SRC_DBRK]) cause[CHAN_LSB +: DCH_W] = chan;
        any = |req;
    end
endmodule

// File: rtl/dbg_entry_unit.sv
// Module: top of the debug exception decision; registers the entry state one cycle after issue.
// Assumes: one instruction per cycle at most; AW and CNT_W do not exceed DW.
module dbg_entry_unit #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 32,
    parameter int LVL_W = 4,
    parameter int DCH_W = 2,
    localparam int CAUSE_W = dbg_entry_pkg::CHAN_LSB + DCH_W,
    localparam int PS_W    = LVL_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [AW-1:0]      issue_pc,
    input  logic               is_brk3,
    input  logic               is_brk2,
    input  logic               dhit,
    input  logic [DCH_W-1:0]   dhit_chan,
    input  logic [LVL_W-1:0]   cur_level,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [DW-1:0]      reg_wdata,
    output logic               take_exc,
    output logic [CAUSE_W-1:0] cause,
    output logic [AW-1:0]      save_pc,
    output logic [PS_W-1:0]    ps_low
);
    import dbg_entry_pkg::*;

    localparam logic [LVL_W-1:0] DBG_LVL  = LVL_W'(DEBUG_LEVEL);
    localparam logic [PS_W-1:0]  PS_ENTRY = {1'b1, DBG_LVL};

    logic                    wr_ib_addr, wr_ib_en, wr_cnt, wr_lvl;
    logic                    ib_hit, ic_fire, gate, any, retire;
    logic [NUM_SRC-1:0]      req;
    logic [CAUSE_W-1:0]      cause_c;

    // Decodes the register write select.
    always_comb begin
        wr_ib_addr = reg_we && (reg_sel == SEL_IB_ADDR);
        wr_ib_en   = reg_we && (reg_sel == SEL_IB_EN);
        wr_cnt     = reg_we && (reg_sel == SEL_ICNT);
        wr_lvl     = reg_we && (reg_sel == SEL_ICLVL);
    end

    dbg_ibreak_unit #(.AW(AW)) u_ibrk (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_addr    (wr_ib_addr),
        .wr_en      (wr_ib_en),
        .wdata_addr (reg_wdata[AW-1:0]),
        .wdata_en   (reg_wdata[0]),
        .pc         (issue_pc),
        .hit        (ib_hit)
    );

    dbg_icount_unit #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_icnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cnt    (wr_cnt),
        .wr_lvl    (wr_lvl),
        .wdata_cnt (reg_wdata[CNT_W-1:0]),
        .wdata_lvl (reg_wdata[LVL_W-1:0]),
        .cur_level (cur_level),
        .retire    (retire),
        .fire      (ic_fire)
    );

    // Gathers trigger requests under the debug-level gate.
    always_comb begin
        gate           = issue_valid && (cur_level < DBG_LVL);
        req            = '0;
        req[SRC_ICOUNT] = gate && ic_fire;
        req[SRC_IBRK]   = gate && ib_hit;
        req[SRC_DBRK]   = gate && dhit;
        req[SRC_BRK3]   = gate && is_brk3;
        req[SRC_BRK2]   = gate && is_brk2;
    end

    dbg_cause_arb #(.DCH_W(DCH_W), .CAUSE_W(CAUSE_W)) u_arb (
        .req   (req),
        .chan  (dhit_chan),
        .cause (cause_c),
        .any   (any)
    );

    // An instruction executes when issued and not replaced by an exception.
    always_comb begin
        retire = issue_valid && !any;
    end

    // Registers the entry state; zero when nothing is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_exc <= 1'b0;
            cause    <= '0;
            save_pc  <= '0;
            ps_low   <= '0;
        end else begin
            take_exc <= any;
            cause    <= any ? cause_c  : '0;
            save_pc  <= any ? issue_pc : '0;
            ps_low   <= any ? PS_ENTRY : '0;
        end
    end
endmodule

// File: rtl/dbg_entry_chk.sv
// Module: property checker for the debug entry unit, bound to the top.
// Assumes: inputs are held for the one cycle in which they are sampled.
module dbg_entry_chk #(
    parameter int AW    = 32,
    parameter int LVL_W = 4,
    parameter int CAUSE_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_valid,
    input logic [AW-1:0]      issue_pc,
    input logic [LVL_W-1:0]   cur_level,
    input logic               take_exc,
    input logic [CAUSE_W-1:0] cause,
    input logic [AW-1:0]      save_pc,
    input logic [LVL_W:0]     ps_low
);
    // R2
    level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_valid) && ($past(cur_level) >= LVL_W'(6))) |-> !take_exc);
    // R3
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> ($countones(cause[4:0]) == 1));
    // R5
    entry_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> (ps_low == (LVL_W+1)'(5'h16)));
    // R5
    entry_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> ($past(issue_valid) && (save_pc == $past(issue_pc))));
    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_exc |-> (cause == '0 && save_pc == '0 && ps_low == '0));
endmodule

bind dbg_entry_unit dbg_entry_chk #(.AW(AW), .LVL_W(LVL_W), .CAUSE_W(CAUSE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_pc    (issue_pc),
    .cur_level   (cur_level),
    .take_exc    (take_exc),
    .cause       (cause),
    .save_pc     (save_pc),
    .ps_low      (ps_low)
);

// File: tb/tb_dbg_entry_unit.sv
module tb_dbg_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_pc = '0;
    logic        is_brk3 = 1'b0, is_brk2 = 1'b0, dhit = 1'b0;
    logic [1:0]  dhit_chan = '0;
    logic [3:0]  cur_level = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        take_exc;
    logic [9:0]  cause;
    logic [31:0] save_pc;
    logic [4:0]  ps_low;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    dbg_entry_unit dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic issue(input logic [31:0] pc, input logic b3, input logic b2,
                         input logic dh, input logic [1:0] ch, input logic [3:0] lvl);
        @(negedge clk);
        issue_valid = 1'b1; issue_pc = pc; is_brk3 = b3; is_brk2 = b2;
        dhit = dh; dhit_chan = ch; cur_level = lvl;
        @(negedge clk);
        issue_valid = 1'b0; is_brk3 = 1'b0; is_brk2 = 1'b0; dhit = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic t, input logic [9:0] c,
                              input logic [31:0] pc);
        chk({tag, " take"}, 64'(take_exc), 64'(t));
        chk({tag, " cause"}, 64'(cause), 64'(c));
        chk({tag, " pc"}, 64'(save_pc), t ? 64'(pc) : 64'd0);
        chk({tag, " ps"}, 64'(ps_low), t ? 64'h16 : 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        expect_out("R1 reset", 1'b0, 10'd0, 32'd0);
        rst_n = 1'b1;
        issue(32'd0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0);
        expect_out("R1 disabled after reset", 1'b0, 10'd0, 32'd0);

        // R2 R3 R4 R5 R10: sweep over levels and trigger mixes, threshold 3
        for (int lvl = 0; lvl < 16; lvl++) begin
            for (int m = 0; m < 24; m++) begin
                logic ic, ib, dh, b3, b2, g, icf;
                logic [1:0] ch;
                logic [31:0] a, pc;
                logic [9:0] ec;
                ic = m[0]; ib = m[1]; dh = m[2];
                b3 = (m / 8) == 1; b2 = (m / 8) == 2;
                ch = 2'(lvl);
                a  = 32'h1000 + 32'(m * 16);
                pc = ib ? a : a + 32'd4;
                wr(2'd0, a);
                wr(2'd1, 32'd1);
                wr(2'd3, 32'd3);
                wr(2'd2, ic ? 32'hFFFF_FFFF : 32'd0);
                issue(pc, b3, b2, dh, ch, 4'(lvl));
                g   = lvl < 6;
                icf = ic && (lvl < 3);
                ec  = '0;
                if (g) begin
                    if (icf)     ec = 10'h001;
                    else if (ib) ec = 10'h002;
                    else if (dh) ec = 10'h004 | (10'(ch) << 8);
                    else if (b3) ec = 10'h008;
                    else if (b2) ec = 10'h010;
                end
                expect_out($sformatf("R2 R3 R4 R5 R10 lvl=%0d mix=%0d", lvl, m),
                           ec != 0, ec, pc);
            end
        end

        // R7: load -2, one instruction runs, next traps; trapped one does not advance
        wr(2'd0, 32'hFFFF_0000);
        wr(2'd3, 32'd1);
        wr(2'd2, 32'hFFFF_FFFE);
        issue(32'h100, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0);
        expect_out("R7 first runs", 1'b0, 10'd0, 32'd0);
        issue(32'h103, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0);
        expect_out("R7 second traps", 1'b1, 10'h001, 32'h103);
        issue(32'h103, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0);
        expect_out("R7 no advance on trap", 1'b1, 10'h001, 32'h103);

        // R7: level at threshold does not count
        wr(2'd3, 32'd2);
        wr(2'd2, 32'hFFFF_FFFE);
        issue(32'h200, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2);
        issue(32'h204, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2);
        expect_out("R7 not eligible", 1'b0, 10'd0, 32'd0);
        issue(32'h208, 1'b0, 1'b0, 1'b0, 2'd0, 4'd1);
        expect_out("R7 counts again", 1'b0, 10'd0, 32'd0);
        issue(32'h20C, 1'b0, 1'b0, 1'b0, 2'd0, 4'd1);
        expect_out("R7 trap after one", 1'b1, 10'h001, 32'h20C);

        // R8: threshold zero disables
        wr(2'd3, 32'd0);
        wr(2'd2, 32'hFFFF_FFFF);
        issue(32'h300, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0);
        expect_out("R8 threshold 0", 1'b0, 10'd0, 32'd0);

        // R6: enable bit 0 only, and clearing stops hits
        wr(2'd0, 32'h40);
        wr(2'd1, 32'd1);
        issue(32'h40, 1'b0, 1'b1, 1'b0, 2'd0, 4'd5);
        expect_out("R6 hit over break", 1'b1, 10'h002, 32'h40);
        wr(2'd1, 32'd2);
        issue(32'h40, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0);
        expect_out("R6 bit0 clear", 1'b0, 10'd0, 32'd0);
        wr(2'd1, 32'd1);
        issue(32'h44, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0);
        expect_out("R6 other pc", 1'b0, 10'd0, 32'd0);

        // R9: write in same cycle as issue is seen only by later instructions
        wr(2'd0, 32'h80);
        @(negedge clk);
        issue_valid = 1'b1; issue_pc = 32'h80; cur_level = 4'd0;
        reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 32'd0;
        @(negedge clk);
        issue_valid = 1'b0; reg_we = 1'b0;
        expect_out("R9 old value used", 1'b1, 10'h002, 32'h80);
        issue(32'h80, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0);
        expect_out("R9 new value used", 1'b0, 10'd0, 32'd0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule